// File: doc/BRIEF.md
# Video Control Register Bus Slave

This block is the serial control port of a video processing register file. It watches a two-wire serial bus (clock and data, open-drain), detects start and stop conditions, and answers to one fixed 7-bit device address. In a write, the byte after the address selects a 4-bit register index. Each following data byte goes to the register bank as a one-cycle write strobe, carrying the index and the data.

The index advances after each data byte and wraps from 0x0F to 0x00. It does not advance when the bank is in its buffered update mode. In that mode only a single data byte is taken per transaction. Indices above 0x0F are refused. The indices 0x0B, 0x0E and 0x0F are accepted, but they produce no strobe. A read transaction returns one status byte assembled from the bank's flag and error inputs.

Both bus lines are sampled on the system clock through two-flop synchronizers. The data line is driven only as an active-high pull-down enable, and it changes only while the clock line is low.

Top module: `vidreg_i2c_slave`

## Requirements
- R1: Only the address bytes 0x88 (write) and 0x89 (read) are acknowledged, which is the 7-bit address 1000100 followed by the direction bit. Any other address byte gets no acknowledge, and the slave ignores the bus until the next START.
- R2: A START is a falling data line while the clock line is high. A STOP is a rising data line while the clock line is high. `busy` is 1 from a START until a STOP and is 0 after reset. The slave never pulls the data line while `busy` is 0.
- R3: A register index byte whose upper four bits are zero is acknowledged and becomes the current index. Any other index byte is not acknowledged, and no strobe or index change follows it.
- R4: Each accepted data byte is acknowledged and gives exactly one `wr_stb` pulse of one cycle, with `wr_sub` set to the current index and `wr_data` set to the byte received, MSB first.
- R5: With `buf_mode`=0, the index increments after each data byte and wraps from 0x0F to 0x00.
- R6: With `buf_mode`=1, the index does not increment. Only the first data byte after the index is accepted; a later one gets no acknowledge and no strobe.
- R7: Data bytes sent to indices 0x0B, 0x0E or 0x0F are acknowledged but produce no strobe. In auto-increment mode the index still advances past them.
- R8: While `bank_ready`=0, a data byte gets no acknowledge and produces no strobe.
- R9: A read sends one byte, MSB first: bit7=`por_flag`, bits6:5=`err_blue`, bits4:3=`err_green`, bits2:1=`err_red`, bit0=0. After the master's acknowledge bit the slave releases the line and goes idle.
- R10: A repeated START returns the slave to address matching. A STOP in the middle of a byte aborts that byte with no strobe.
- R11: `sda_oe`=1 pulls the data line low. It is 0 after reset and changes only while `scl_in` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_in | input | 1 | Raw bus clock line |
| sda_in | input | 1 | Raw bus data line (wired level) |
| sda_oe | output | 1 | Data line pull-down enable |
| buf_mode | input | 1 | Buffered update mode: 1 disables auto-increment |
| bank_ready | input | 1 | Register bank can accept a write |
| por_flag | input | 1 | Power-on-reset flag for the status byte |
| err_blue | input | 2 | Blue white-level error |
| err_green | input | 2 | Green white-level error |
| err_red | input | 2 | Red white-level error |
| busy | output | 1 | Bus busy between START and STOP |
| wr_stb | output | 1 | One-cycle register write strobe |
| wr_sub | output | 4 | Register index of the write |
| wr_data | output | 8 | Data of the write |

States of the control FSM are as follows:
- IDLE waits for a START.
- ADDR shifts in the address byte.
- ADDR_ACK drives the address acknowledge, then moves to SUB (write) or READ (read).
- SUB shifts in the index byte.
- SUB_ACK drives the index acknowledge, then moves to DATA.
- DATA shifts in a data byte.
- DATA_ACK drives the data acknowledge, then returns to DATA.
- READ shifts out the status byte.
- READ_ACK releases the line for the master's acknowledge bit, then moves to IDLE.

Any byte that is refused goes to IDLE. A START enters ADDR from any state, and a STOP enters IDLE from any state.

## Verification
The bench sweeps all 256 address bytes. A wrong compare width or a wrongly handled direction bit would acknowledge a foreign address or miss the read address. It also sweeps index bytes across and beyond the valid range. A slave that checked too few upper bits would strobe for index 0x10 and above, and one that dropped the reserved set would emit strobes for 0x0B, 0x0E and 0x0F. A burst that starts at 0x0C exposes a counter that saturates instead of wrapping, or one that skips the reserved indices. Buffered mode, a not-ready bank, a repeated START and a STOP in the middle of a byte each catch a slave that keeps writing when it must refuse or abort.

// File: rtl/vidreg_i2c_pkg.sv
package vidreg_i2c_pkg;
    localparam int BYTE_W = 8;
    localparam int CNT_W  = $clog2(BYTE_W + 1);

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_SUB,
        ST_SUB_ACK,
        ST_DATA,
        ST_DATA_ACK,
        ST_READ,
        ST_READ_ACK
    } bus_state_t;
endpackage

// File: rtl/vidreg_i2c_sync.sv
module vidreg_i2c_sync #(
    parameter int WIDTH  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_in,
    output logic [WIDTH-1:0] d_out
);
    for (genvar g = 0; g < WIDTH; g++) begin : g_line
        logic [STAGES-1:0] chain;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain <= '1;
            else        chain <= {chain[STAGES-2:0], d_in[g]};
        end
        assign d_out[g] = chain[STAGES-1];
    end
endmodule

// File: rtl/vidreg_i2c_cond.sv
module vidreg_i2c_cond (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_s,
    input  logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_c,
    output logic stop_c
);
    logic scl_q, sda_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_s;
            sda_q <= sda_s;
        end
    end

    assign scl_rise = scl_s & ~scl_q;
    assign scl_fall = ~scl_s & scl_q;
    assign start_c  = scl_s & scl_q & sda_q & ~sda_s;
    assign stop_c   = scl_s & scl_q & ~sda_q & sda_s;
endmodule

// File: rtl/vidreg_i2c_slave.sv
module vidreg_i2c_slave
    import vidreg_i2c_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR    = 7'b1000100,
    parameter int         SUB_W       = 4,
    parameter int         SYNC_STAGES = 2,
    parameter logic [(1<<SUB_W)-1:0] RSVD_MASK = 16'hC800
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             scl_in,
    input  logic             sda_in,
    output logic             sda_oe,
    input  logic             buf_mode,
    input  logic             bank_ready,
    input  logic             por_flag,
    input  logic [1:0]       err_blue,
    input  logic [1:0]       err_green,
    input  logic [1:0]       err_red,
    output logic             busy,
    output logic             wr_stb,
    output logic [SUB_W-1:0] wr_sub,
    output logic [7:0]       wr_data
);
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(BYTE_W);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(BYTE_W - 1);

    logic [1:0] sync_o;
    logic       scl_s, sda_s;
    logic       scl_rise, scl_fall, start_c, stop_c;

    vidreg_i2c_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_in  ({scl_in, sda_in}),
        .d_out (sync_o)
    );
    assign scl_s = sync_o[1];
    assign sda_s = sync_o[0];

    vidreg_i2c_cond u_cond (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_s    (scl_s),
        .sda_s    (sda_s),
        .scl_rise (scl_rise),
        .scl_fall (scl_fall),
        .start_c  (start_c),
        .stop_c   (stop_c)
    );

    bus_state_t        state;
    logic [CNT_W-1:0]  cnt;
    logic [BYTE_W-1:0] sh, tx;
    logic [SUB_W-1:0]  sub;
    logic              rd_q, got_one, busy_q;
    logic              stb_q;
    logic [SUB_W-1:0]  stb_sub;
    logic [BYTE_W-1:0] stb_data;
    logic              byte_done;

    assign byte_done = scl_fall && (cnt == CNT_FULL);

    // state register and datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            cnt      <= '0;
            sh       <= '0;
            tx       <= '0;
            sub      <= '0;
            rd_q     <= 1'b0;
            got_one  <= 1'b0;
            busy_q   <= 1'b0;
            stb_q    <= 1'b0;
            stb_sub  <= '0;
            stb_data <= '0;
        end else begin
            stb_q <= 1'b0;
            if (start_c) begin
                busy_q <= 1'b1;
                state  <= ST_ADDR;
                cnt    <= '0;
            end else if (stop_c) begin
                busy_q <= 1'b0;
                state  <= ST_IDLE;
            end else begin
                unique case (state)
                    ST_IDLE: ;
                    ST_ADDR: begin
                        if (scl_rise) begin
                            sh  <= {sh[BYTE_W-2:0], sda_s};
                            cnt <= cnt + 1'b1;
                        end else if (byte_done) begin
                            cnt <= '0;
                            if (sh[BYTE_W-1:1] == DEV_ADDR) begin
                                rd_q  <= sh[0];
                                state <= ST_ADDR_ACK;
                            end else begin
                                state <= ST_IDLE;
                            end
                        end
                    end
                    ST_ADDR_ACK: begin
                        if (scl_fall) begin
                            if (rd_q) begin
                                tx    <= {por_flag, err_blue, err_green, err_red, 1'b0};
                                cnt   <= '0;
                                state <= ST_READ;
                            end else begin
                                state <= ST_SUB;
                            end
                        end
                    end
                    ST_SUB: begin
                        if (scl_rise) begin
                            sh  <= {sh[BYTE_W-2:0], sda_s};
                            cnt <= cnt + 1'b1;
                        end else if (byte_done) begin
                            cnt <= '0;
                            if (sh[BYTE_W-1:SUB_W] == '0) begin
                                sub     <= sh[SUB_W-1:0];
                                got_one <= 1'b0;
                                state   <= ST_SUB_ACK;
                            end else begin
                                state <= ST_IDLE;
                            end
                        end
                    end
                    ST_SUB_ACK: begin
                        if (scl_fall) state <= ST_DATA;
                    end
                    ST_DATA: begin
                        if (scl_rise) begin
                            sh  <= {sh[BYTE_W-2:0], sda_s};
                            cnt <= cnt + 1'b1;
                        end else if (byte_done) begin
                            cnt <= '0;
                            if (bank_ready && !(buf_mode && got_one)) begin
                                got_one <= 1'b1;
                                state   <= ST_DATA_ACK;
                                if (!RSVD_MASK[sub]) begin
                                    stb_q    <= 1'b1;
                                    stb_sub  <= sub;
                                    stb_data <= sh;
                                end
                                if (!buf_mode) sub <= sub + 1'b1;
                            end else begin
                                state <= ST_IDLE;
                            end
                        end
                    end
                    ST_DATA_ACK: begin
                        if (scl_fall) state <= ST_DATA;
                    end
                    ST_READ: begin
                        if (scl_fall) begin
                            if (cnt == CNT_LAST) begin
                                state <= ST_READ_ACK;
                            end else begin
                                tx  <= {tx[BYTE_W-2:0], 1'b0};
                                cnt <= cnt + 1'b1;
                            end
                        end
                    end
                    ST_READ_ACK: begin
                        if (scl_fall) state <= ST_IDLE;
                    end
                endcase
            end
        end
    end

    // outputs
    always_comb begin
        sda_oe = 1'b0;
        unique case (state)
            ST_ADDR_ACK, ST_SUB_ACK, ST_DATA_ACK: sda_oe = 1'b1;
            ST_READ:                              sda_oe = ~tx[BYTE_W-1];
            default:                              sda_oe = 1'b0;
        endcase
        busy    = busy_q;
        wr_stb  = stb_q;
        wr_sub  = stb_sub;
        wr_data = stb_data;
    end
endmodule

// File: rtl/vidreg_i2c_chk.sv
module vidreg_i2c_chk #(
    parameter int SUB_W = 4,
    parameter logic [(1<<SUB_W)-1:0] RSVD_MASK = 16'hC800
) (
    input logic             clk,
    input logic             rst_n,
    input logic             scl_in,
    input logic             sda_oe,
    input logic             busy,
    input logic             wr_stb,
    input logic [SUB_W-1:0] wr_sub,
    input logic             bank_ready
);
    AST_IDLE_NO_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !sda_oe); // R2
    AST_STB_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb |=> !wr_stb); // R4
    AST_STB_IN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb |-> busy); // R4
    AST_RSVD_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb |-> !RSVD_MASK[wr_sub]); // R7
    AST_READY_GATE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb |-> $past(bank_ready)); // R8
    AST_SDA_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_oe) |-> !scl_in); // R11
endmodule

bind vidreg_i2c_slave vidreg_i2c_chk #(.SUB_W(SUB_W), .RSVD_MASK(RSVD_MASK)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .scl_in     (scl_in),
    .sda_oe     (sda_oe),
    .busy       (busy),
    .wr_stb     (wr_stb),
    .wr_sub     (wr_sub),
    .bank_ready (bank_ready)
);

// File: tb/sim_vidreg_i2c_slave.sv
module sim_vidreg_i2c_slave;
    localparam int Q = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       scl_m = 1'b1;
    logic       sda_m = 1'b1;
    logic       buf_mode = 1'b0;
    logic       bank_ready = 1'b1;
    logic       por_flag = 1'b0;
    logic [1:0] err_blue = 2'd0, err_green = 2'd0, err_red = 2'd0;
    logic       sda_oe, busy, wr_stb;
    logic [3:0] wr_sub;
    logic [7:0] wr_data;
    wire        sda_bus = sda_m & ~sda_oe;

    int n_chk = 0;
    int n_bad = 0;
    int stb_n = 0;
    logic [3:0] log_sub [0:63];
    logic [7:0] log_dat [0:63];

    always #2.5 clk = ~clk;

    vidreg_i2c_slave u0 (
        .clk(clk), .rst_n(rst_n), .scl_in(scl_m), .sda_in(sda_bus), .sda_oe(sda_oe),
        .buf_mode(buf_mode), .bank_ready(bank_ready), .por_flag(por_flag),
        .err_blue(err_blue), .err_green(err_green), .err_red(err_red),
        .busy(busy), .wr_stb(wr_stb), .wr_sub(wr_sub), .wr_data(wr_data)
    );

    always @(negedge clk) begin
        if (rst_n && wr_stb) begin
            log_sub[stb_n % 64] = wr_sub;
            log_dat[stb_n % 64] = wr_data;
            stb_n = stb_n + 1;
        end
    end

    task automatic chk(input logic ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic wq;
        repeat (Q) @(negedge clk);
    endtask

    task automatic bus_start;
        sda_m = 1'b1; wq; scl_m = 1'b1; wq; sda_m = 1'b0; wq; scl_m = 1'b0; wq;
    endtask

    task automatic bus_stop;
        sda_m = 1'b0; wq; scl_m = 1'b1; wq; sda_m = 1'b1; wq; wq;
    endtask

    task automatic bit_out(input logic b);
        sda_m = b; wq; scl_m = 1'b1; wq; wq; scl_m = 1'b0; wq;
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ack);
        for (int i = 7; i >= 0; i--) bit_out(b[i]);
        sda_m = 1'b1; wq; scl_m = 1'b1; wq; ack = ~sda_bus; wq; scl_m = 1'b0; wq;
    endtask

    task automatic recv_byte(output logic [7:0] b, input logic mack);
        for (int i = 7; i >= 0; i--) begin
            sda_m = 1'b1; wq; scl_m = 1'b1; wq; b[i] = sda_bus; wq; scl_m = 1'b0; wq;
        end
        bit_out(~mack);
    endtask

    // one-byte write: returns acks of index and data
    task automatic write1(input logic [7:0] s, input logic [7:0] d,
                          output logic a_sub, output logic a_dat);
        logic a;
        bus_start;
        send_byte(8'h88, a);
        send_byte(s, a_sub);
        send_byte(d, a_dat);
        bus_stop;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic a, a1, a2;
        logic [7:0] rb, expb;
        int s0;

        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        // R11 / R2 reset state
        chk(sda_oe == 1'b0, "R11 reset sda_oe", sda_oe, 0);
        chk(busy == 1'b0, "R2 reset busy", busy, 0);
        chk(wr_stb == 1'b0, "R4 reset wr_stb", wr_stb, 0);

        // R1 address sweep, R9 read on 0x89
        for (int ad = 0; ad < 256; ad++) begin
            por_flag = ad[0]; err_blue = ad[2:1]; err_green = ad[4:3]; err_red = ad[6:5];
            bus_start;
            chk(busy == 1'b1, "R2 busy after START", busy, 1);
            send_byte(8'(ad), a);
            chk(a == (ad == 8'h88 || ad == 8'h89), "R1 address ack", a, (ad == 8'h88 || ad == 8'h89));
            if (ad == 8'h89) begin
                recv_byte(rb, 1'b0);
                expb = {por_flag, err_blue, err_green, err_red, 1'b0};
                chk(rb == expb, "R9 status byte", rb, expb);
            end
            bus_stop;
            chk(busy == 1'b0, "R2 busy after STOP", busy, 0);
        end
        // R9 more status patterns
        for (int p = 0; p < 8; p++) begin
            por_flag = p[0]; err_blue = {p[1], p[0]}; err_green = {p[2], ~p[1]}; err_red = 2'(3 - p[1:0]);
            bus_start;
            send_byte(8'h89, a);
            recv_byte(rb, 1'b0);
            bus_stop;
            expb = {por_flag, err_blue, err_green, err_red, 1'b0};
            chk(rb == expb, "R9 status pattern", rb, expb);
        end

        // R3 / R4 / R7 index sweep
        for (int s = 0; s < 36; s++) begin
            logic [7:0] sb;
            logic in_rng, rsv;
            sb = (s < 32) ? 8'(s) : ((s == 32) ? 8'h40 : (s == 33) ? 8'h80 : (s == 34) ? 8'hF0 : 8'hFF);
            in_rng = (sb < 8'h10);
            rsv = in_rng && (sb == 8'h0B || sb == 8'h0E || sb == 8'h0F);
            s0 = stb_n;
            write1(sb, sb ^ 8'hA5, a1, a2);
            chk(a1 == in_rng, "R3 index ack", a1, in_rng);
            chk(a2 == in_rng, "R7 data ack", a2, in_rng);
            chk((stb_n - s0) == int'(in_rng && !rsv), "R7 strobe count", stb_n - s0, int'(in_rng && !rsv));
            if (in_rng && !rsv) begin
                chk(log_sub[s0 % 64] == sb[3:0], "R4 wr_sub", log_sub[s0 % 64], sb[3:0]);
                chk(log_dat[s0 % 64] == (sb ^ 8'hA5), "R4 wr_data", log_dat[s0 % 64], sb ^ 8'hA5);
            end
        end

        // R5 auto-increment with wrap, skipping reserved
        begin
            logic [3:0] exps [0:3];
            exps[0] = 4'hC; exps[1] = 4'hD; exps[2] = 4'h0; exps[3] = 4'h1;
            buf_mode = 1'b0;
            s0 = stb_n;
            bus_start;
            send_byte(8'h88, a);
            send_byte(8'h0C, a);
            for (int k = 0; k < 6; k++) begin
                send_byte(8'h10 + 8'(k), a);
                chk(a == 1'b1, "R5 burst ack", a, 1);
            end
            bus_stop;
            chk((stb_n - s0) == 4, "R5 burst strobes", stb_n - s0, 4);
            for (int k = 0; k < 4; k++) begin
                int dk;
                dk = (k < 2) ? k : k + 2;
                chk(log_sub[(s0 + k) % 64] == exps[k], "R5 wrap index", log_sub[(s0 + k) % 64], exps[k]);
                chk(log_dat[(s0 + k) % 64] == 8'(8'h10 + dk), "R5 burst data", log_dat[(s0 + k) % 64], 8'h10 + dk);
            end
        end

        // R6 buffered mode: one byte only
        buf_mode = 1'b1;
        s0 = stb_n;
        bus_start;
        send_byte(8'h88, a);
        send_byte(8'h03, a);
        send_byte(8'h5A, a1);
        send_byte(8'h77, a2);
        bus_stop;
        chk(a1 == 1'b1, "R6 first byte ack", a1, 1);
        chk(a2 == 1'b0, "R6 second byte nack", a2, 0);
        chk((stb_n - s0) == 1, "R6 strobe count", stb_n - s0, 1);
        chk(log_sub[s0 % 64] == 4'h3, "R6 no increment index", log_sub[s0 % 64], 3);
        buf_mode = 1'b0;

        // R8 bank not ready
        bank_ready = 1'b0;
        s0 = stb_n;
        write1(8'h02, 8'h99, a1, a2);
        chk(a2 == 1'b0, "R8 data nack when not ready", a2, 0);
        chk((stb_n - s0) == 0, "R8 no strobe", stb_n - s0, 0);
        bank_ready = 1'b1;

        // R10 repeated START into read
        por_flag = 1'b1; err_blue = 2'd2; err_green = 2'd1; err_red = 2'd3;
        s0 = stb_n;
        bus_start;
        send_byte(8'h88, a);
        send_byte(8'h05, a);
        bus_start;
        send_byte(8'h89, a);
        chk(a == 1'b1, "R10 address ack after repeated START", a, 1);
        recv_byte(rb, 1'b0);
        bus_stop;
        chk(rb == 8'b1_10_01_11_0, "R10 status after repeated START", rb, 8'b1_10_01_11_0);
        chk((stb_n - s0) == 0, "R10 no strobe", stb_n - s0, 0);

        // R10 STOP mid-byte aborts
        s0 = stb_n;
        bus_start;
        send_byte(8'h88, a);
        send_byte(8'h04, a);
        bit_out(1'b0); bit_out(1'b1); bit_out(1'b1);
        bus_stop;
        chk((stb_n - s0) == 0, "R10 aborted byte no strobe", stb_n - s0, 0);
        write1(8'h02, 8'h3C, a1, a2);
        chk(a2 == 1'b1 && (stb_n - s0) == 1 && log_dat[s0 % 64] == 8'h3C,
            "R10 write after abort", log_dat[s0 % 64], 8'h3C);
        chk(sda_oe == 1'b0, "R11 released when idle", sda_oe, 0);

        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule